// File: doc/BRIEF.md
# Sound Coprocessor Address Decoder

This block sits between the 8-bit CPU of a sound coprocessor and everything that CPU can address. It looks at every 16-bit address and steers each read or write to one of four targets: the external 64 KiB RAM, a 64-byte boot ROM that overlays the top of the address space for reads only, an indirect index/data register pair that reaches the DSP register file, or three interval timers.

The sixteen addresses 0x00F0 to 0x00FF form an I/O page. Each location there has its own read and write meaning. Some are write-only registers that read as zero. Some counters clear when read. Four port bytes live inside the block, so that one control write can clear them in a single cycle. Every address outside the I/O page goes straight to RAM. The only exception is a read from the overlay window while the overlay is enabled.

Reads are combinational. The RAM and the DSP must return their data in the same cycle as the address they are given. All register updates take effect on the rising clock edge.

Top module: `aio_decoder`

## Requirements
- R1: After reset the boot ROM overlay is enabled, the DSP index reads as 0x00, all three timers are stopped and every timer counter reads as 0.
- R2: An access to any address outside 0x00F0–0x00FF, other than an overlay read, goes to RAM. A write raises `ram_we` with `ram_addr` and `ram_wdata` equal to the CPU address and data. A read returns `ram_rdata`.
- R3: While control bit 7 is 1, a read from 0xFFC0–0xFFFF returns boot ROM byte i = addr − 0xFFC0, whose value is ((i·29) mod 256) XOR 0xA5. While bit 7 is 0, such a read returns RAM. A write to that range always goes to RAM.
- R4: Reads of 0x00F0, 0x00F1, 0x00FA, 0x00FB and 0x00FC return 0x00. A write to 0x00F0 has no effect, and no write to 0x00F0–0x00F3 or 0x00FA–0x00FF raises `ram_we`.
- R5: 0x00F2 is a readable and writable 8-bit DSP index that drives `dsp_idx`. A write to 0x00F3 pulses `dsp_we` with `dsp_wdata` equal to the CPU data. A read of 0x00F3 returns `dsp_rdata`.
- R6: Writes to 0x00F4–0x00F9 are passed to RAM at the same address. Reads of 0x00F8 and 0x00F9 return RAM. Reads of 0x00F4–0x00F7 return the last byte written there, which the block holds itself.
- R7: A write to the control register 0x00F1 with bit 4 set clears the port bytes 0x00F4 and 0x00F5. The same write with bit 5 set clears 0x00F6 and 0x00F7.
- R8: Writes to the counter addresses 0x00FD–0x00FF are ignored: they do not write RAM and do not change any counter.
- R9: Control bits 0, 1 and 2 run timers 0, 1 and 2. A timer whose bit goes from 0 to 1 resets its prescaler, its stage count and its output counter. A running timer ticks every 256, 256 and 32 clocks respectively, with the first tick that many clocks after the starting write. On each tick the stage count advances. When the stage count reaches the target it returns to zero and the output counter increments. A target of 0 means 256.
- R10: The output counter is 4 bits wide and wraps from 15 to 0. Reading 0x00FD, 0x00FE or 0x00FF returns that timer's counter in bits 3:0, with bits 7:4 zero. The read clears the counter. If a stage wrap happens in the same cycle as the read, the counter becomes 1.
- R11: Clearing a timer's run bit freezes its prescaler, stage count and output counter.
- R12: Writes to 0x00FA, 0x00FB and 0x00FC set the 8-bit targets of timers 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Read data to the CPU (combinational) |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data, same cycle |
| dsp_idx | output | 8 | Current DSP register index |
| dsp_wdata | output | 8 | DSP register write data |
| dsp_we | output | 1 | DSP register write enable |
| dsp_rdata | input | 8 | DSP register read data, same cycle |

## Verification
The decoder is exercised with accesses to plain RAM, to the addresses on both sides of the overlay boundary with the overlay enabled and disabled, and to every I/O location, each both written and read. This separates RAM-backed locations from locally held bytes and from write-only registers. The timers are run with targets 1, 2, 3 and 0, on both prescaler rates. A stream of back-to-back counter reads is included, so that some reads coincide with a stage wrap and some do not. Timers are also stopped and restarted, which distinguishes freezing from resetting. Every cycle the enables and the DSP index are compared against a behavioural model, and every read is compared against the model's expected data.

// File: rtl/aio_pkg.sv
package aio_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int NUM_TMR    = 3;
    localparam int NUM_PORT   = 4;
    localparam int ROM_BYTES  = 64;
    localparam int ROM_AW     = $clog2(ROM_BYTES);
    localparam int CNT_W      = 4;
    localparam int STAGE_W    = 8;

    localparam logic [ADDR_W-5:0] IO_PAGE = 12'h00F;

    // control register bit positions (software-visible layout)
    localparam int CTRL_ROM_BIT = 7;
    localparam int CTRL_C23_BIT = 5;
    localparam int CTRL_C01_BIT = 4;

    localparam logic [3:0] TGT_OFS = 4'hA;
    localparam logic [3:0] CNT_OFS = 4'hD;

    typedef enum logic [3:0] {
        IO_TEST  = 4'h0,
        IO_CTRL  = 4'h1,
        IO_DIDX  = 4'h2,
        IO_DDAT  = 4'h3,
        IO_PORT0 = 4'h4,
        IO_PORT1 = 4'h5,
        IO_PORT2 = 4'h6,
        IO_PORT3 = 4'h7,
        IO_SPR0  = 4'h8,
        IO_SPR1  = 4'h9,
        IO_TGT0  = 4'hA,
        IO_TGT1  = 4'hB,
        IO_TGT2  = 4'hC,
        IO_CNT0  = 4'hD,
        IO_CNT1  = 4'hE,
        IO_CNT2  = 4'hF
    } io_reg_e;

    typedef struct packed {
        logic               rom_en;
        logic [NUM_TMR-1:0] run;
    } ctrl_t;

    typedef struct packed {
        logic    io;
        logic    rom;
        io_reg_e sel;
    } dec_t;

    function automatic int unsigned tmr_div(input int idx);
        return (idx == NUM_TMR - 1) ? 32 : 256;
    endfunction

    function automatic logic [DATA_W-1:0] boot_byte(input logic [ROM_AW-1:0] i);
        logic [DATA_W-1:0] p;
        p = DATA_W'(i) * 8'd29;
        return p ^ 8'hA5;
    endfunction

endpackage

// File: rtl/aio_timer.sv
module aio_timer
    import aio_pkg::*;
#(
    parameter int unsigned DIV = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_i,
    input  logic               start_i,
    input  logic               tgt_we_i,
    input  logic [STAGE_W-1:0] tgt_i,
    input  logic               clr_i,
    output logic [CNT_W-1:0]   count_o
);

    localparam int PW = $clog2(DIV);

    logic [PW-1:0]      presc_q;
    logic [STAGE_W-1:0] stage_q;
    logic [STAGE_W-1:0] tgt_q;
    logic [CNT_W-1:0]   count_q;
    logic               tick;
    logic               wrap;

    assign tick = run_i && (presc_q == PW'(DIV - 1));
    assign wrap = tick && (stage_q == tgt_q - 8'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
            stage_q <= '0;
            tgt_q   <= '0;
            count_q <= '0;
        end else begin
            if (tgt_we_i) tgt_q <= tgt_i;
            if (start_i) begin
                presc_q <= '0;
                stage_q <= '0;
                count_q <= '0;
            end else begin
                if (run_i) presc_q <= presc_q + PW'(1);
                if (tick)  stage_q <= wrap ? '0 : stage_q + 8'd1;
                count_q <= (clr_i ? '0 : count_q) + CNT_W'(wrap);
            end
        end
    end

    assign count_o = count_q;

    a_r9_start_zero: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (stage_q == '0 && count_q == '0));

    a_r11_freeze: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !start_i && !clr_i) |=> ($stable(count_q) && $stable(stage_q) && $stable(presc_q)));

    a_r10_single_step: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !clr_i) |=> (count_q == $past(count_q) || count_q == $past(count_q) + 4'd1));

    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !start_i) |=> (count_q <= 4'd1));

endmodule

// File: rtl/aio_ctrl.sv
module aio_ctrl
    import aio_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_i,
    input  dec_t                           dec_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output ctrl_t                          ctrl_o,
    output logic [DATA_W-1:0]              didx_o,
    output logic [NUM_PORT-1:0][DATA_W-1:0] port_o,
    output logic [NUM_TMR-1:0]             start_o
);

    ctrl_t                           ctrl_q;
    logic [DATA_W-1:0]               didx_q;
    logic [NUM_PORT-1:0][DATA_W-1:0] port_q;
    logic                            wr_ctrl;
    logic                            wr_didx;
    logic                            wr_port;

    assign wr_ctrl = wr_i && dec_i.io && (dec_i.sel == IO_CTRL);
    assign wr_didx = wr_i && dec_i.io && (dec_i.sel == IO_DIDX);
    assign wr_port = wr_i && dec_i.io && (dec_i.sel inside {IO_PORT0, IO_PORT1, IO_PORT2, IO_PORT3});

    assign start_o = {NUM_TMR{wr_ctrl}} & wdata_i[NUM_TMR-1:0] & ~ctrl_q.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.rom_en <= 1'b1;
            ctrl_q.run    <= '0;
            didx_q        <= '0;
            port_q        <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.rom_en <= wdata_i[CTRL_ROM_BIT];
                ctrl_q.run    <= wdata_i[NUM_TMR-1:0];
                if (wdata_i[CTRL_C01_BIT]) begin
                    port_q[0] <= '0;
                    port_q[1] <= '0;
                end
                if (wdata_i[CTRL_C23_BIT]) begin
                    port_q[2] <= '0;
                    port_q[3] <= '0;
                end
            end
            if (wr_didx) didx_q <= wdata_i;
            if (wr_port) port_q[dec_i.sel[1:0]] <= wdata_i;
        end
    end

    assign ctrl_o = ctrl_q;
    assign didx_o = didx_q;
    assign port_o = port_q;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (ctrl_q.rom_en && didx_q == '0 && ctrl_q.run == '0));

    a_r7_clear_low: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wdata_i[CTRL_C01_BIT]) |=> (port_q[0] == '0 && port_q[1] == '0));

    a_r7_clear_high: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wdata_i[CTRL_C23_BIT]) |=> (port_q[2] == '0 && port_q[3] == '0));

endmodule

// File: rtl/aio_decoder.sv
module aio_decoder
    import aio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] dsp_idx,
    output logic [DATA_W-1:0] dsp_wdata,
    output logic              dsp_we,
    input  logic [DATA_W-1:0] dsp_rdata
);

    dec_t                            dec;
    ctrl_t                           ctrl;
    logic [DATA_W-1:0]               didx;
    logic [NUM_PORT-1:0][DATA_W-1:0] port;
    logic [NUM_TMR-1:0]              start;
    logic [NUM_TMR-1:0][CNT_W-1:0]   cnt;
    logic                            io_ram_pass;

    assign dec.io  = (cpu_addr[ADDR_W-1:4] == IO_PAGE);
    assign dec.rom = ctrl.rom_en && (&cpu_addr[ADDR_W-1:ROM_AW]);
    assign dec.sel = io_reg_e'(cpu_addr[3:0]);

    assign io_ram_pass = dec.sel inside {IO_PORT0, IO_PORT1, IO_PORT2, IO_PORT3, IO_SPR0, IO_SPR1};

    assign ram_addr  = cpu_addr;
    assign ram_wdata = cpu_wdata;
    assign ram_we    = cpu_wr && (!dec.io || io_ram_pass);

    assign dsp_idx   = didx;
    assign dsp_wdata = cpu_wdata;
    assign dsp_we    = cpu_wr && dec.io && (dec.sel == IO_DDAT);

    aio_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (cpu_wr),
        .dec_i   (dec),
        .wdata_i (cpu_wdata),
        .ctrl_o  (ctrl),
        .didx_o  (didx),
        .port_o  (port),
        .start_o (start)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        logic tgt_we;
        logic clr;
        assign tgt_we = cpu_wr && dec.io && (cpu_addr[3:0] == TGT_OFS + 4'(g));
        assign clr    = cpu_rd && dec.io && (cpu_addr[3:0] == CNT_OFS + 4'(g));
        aio_timer #(.DIV(tmr_div(g))) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .run_i    (ctrl.run[g]),
            .start_i  (start[g]),
            .tgt_we_i (tgt_we),
            .tgt_i    (cpu_wdata),
            .clr_i    (clr),
            .count_o  (cnt[g])
        );
    end

    always_comb begin
        cpu_rdata = ram_rdata;
        if (dec.io) begin
            case (dec.sel)
                IO_TEST, IO_CTRL,
                IO_TGT0, IO_TGT1, IO_TGT2:      cpu_rdata = '0;
                IO_DIDX:                        cpu_rdata = didx;
                IO_DDAT:                        cpu_rdata = dsp_rdata;
                IO_PORT0, IO_PORT1,
                IO_PORT2, IO_PORT3:             cpu_rdata = port[dec.sel[1:0]];
                IO_SPR0, IO_SPR1:               cpu_rdata = ram_rdata;
                IO_CNT0:                        cpu_rdata = {4'b0, cnt[0]};
                IO_CNT1:                        cpu_rdata = {4'b0, cnt[1]};
                IO_CNT2:                        cpu_rdata = {4'b0, cnt[2]};
                default:                        cpu_rdata = '0;
            endcase
        end else if (dec.rom) begin
            cpu_rdata = boot_byte(cpu_addr[ROM_AW-1:0]);
        end
    end

    a_r4_io_no_ram: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && dec.io && !(cpu_addr[3:0] inside {[4'h4:4'h9]})) |-> !ram_we);

    a_r5_dsp_exclusive: assert property (@(posedge clk) disable iff (rst)
        dsp_we |-> (!ram_we && $countones(start) == 0));

endmodule

// File: tb/aio_decoder_bench.sv
module aio_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_we;
    logic [7:0]  ram_rdata;
    logic [7:0]  dsp_idx;
    logic [7:0]  dsp_wdata;
    logic        dsp_we;
    logic [7:0]  dsp_rdata;

    always #2 clk = ~clk;

    aio_decoder u_aio_decoder (
        .clk(clk), .rst(rst),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_rdata(cpu_rdata),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
        .dsp_idx(dsp_idx), .dsp_wdata(dsp_wdata), .dsp_we(dsp_we), .dsp_rdata(dsp_rdata)
    );

    // environment: RAM covering pages 0x00xx and 0xFFxx, and a DSP register file
    logic [7:0] mem [0:511];
    logic [7:0] dsp_mem [0:255];
    assign ram_rdata = mem[{ram_addr[15], ram_addr[7:0]}];
    assign dsp_rdata = dsp_mem[dsp_idx];
    always @(posedge clk) begin
        if (ram_we) mem[{ram_addr[15], ram_addr[7:0]}] <= ram_wdata;
        if (dsp_we) dsp_mem[dsp_idx] <= dsp_wdata;
    end

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // behavioural reference model
    int m_rom, m_idx, m_run;
    int m_port [4];
    int m_tgt [3], m_pre [3], m_stg [3], m_cnt [3];

    function automatic int div_of(int i);
        return (i == 2) ? 32 : 256;
    endfunction

    function automatic int exp_read(logic [15:0] a);
        int lo;
        lo = a[3:0];
        if (a[15:4] == 12'h00F) begin
            if (lo == 0 || lo == 1 || (lo >= 10 && lo <= 12)) return 0;
            if (lo == 2) return m_idx;
            if (lo == 3) return dsp_mem[m_idx];
            if (lo >= 4 && lo <= 7) return m_port[lo-4];
            if (lo == 8 || lo == 9) return mem[{1'b0, a[7:0]}];
            return m_cnt[lo-13];
        end
        if (m_rom != 0 && a >= 16'hFFC0) return (((a - 16'hFFC0) * 29) & 255) ^ 8'hA5;
        return mem[{a[15], a[7:0]}];
    endfunction

    task automatic model_reset();
        m_rom = 1; m_idx = 0; m_run = 0;
        for (int i = 0; i < 4; i++) m_port[i] = 0;
        for (int i = 0; i < 3; i++) begin
            m_tgt[i] = 0; m_pre[i] = 0; m_stg[i] = 0; m_cnt[i] = 0;
        end
    endtask

    task automatic model_step(logic [15:0] a, logic [7:0] d, bit rd, bit wr);
        bit io;
        int lo;
        io = (a[15:4] == 12'h00F);
        lo = a[3:0];
        for (int i = 0; i < 3; i++) begin
            bit oldrun, tick, clr, start;
            int inc;
            oldrun = m_run[i];
            tick   = oldrun && (m_pre[i] == div_of(i) - 1);
            clr    = rd && io && (lo == 13 + i);
            start  = wr && io && (lo == 1) && d[i] && !oldrun;
            inc    = 0;
            if (start) begin
                m_pre[i] = 0; m_stg[i] = 0; m_cnt[i] = 0;
            end else begin
                if (oldrun) m_pre[i] = (m_pre[i] + 1) % div_of(i);
                if (tick) begin
                    if (m_stg[i] == ((m_tgt[i] + 255) & 255)) begin
                        m_stg[i] = 0; inc = 1;
                    end else m_stg[i] = (m_stg[i] + 1) & 255;
                end
                m_cnt[i] = ((clr ? 0 : m_cnt[i]) + inc) & 15;
            end
            if (wr && io && lo == 10 + i) m_tgt[i] = d;
        end
        if (wr && io && lo == 1) begin
            m_run = d[2:0];
            m_rom = d[7];
            if (d[4]) begin m_port[0] = 0; m_port[1] = 0; end
            if (d[5]) begin m_port[2] = 0; m_port[3] = 0; end
        end
        if (wr && io && lo == 2) m_idx = d;
        if (wr && io && lo >= 4 && lo <= 7) m_port[lo-4] = d;
    endtask

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(logic [15:0] a, logic [7:0] d, bit rd, bit wr, string tag);
        bit io, ewe;
        int lo;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr;
        #1;
        io  = (a[15:4] == 12'h00F);
        lo  = a[3:0];
        ewe = wr && (!io || (lo >= 4 && lo <= 9));
        chk({tag, " ram_we"}, ram_we, ewe);
        chk({tag, " dsp_we"}, dsp_we, wr && io && lo == 3);
        chk({tag, " dsp_idx"}, dsp_idx, m_idx);
        if (ewe) begin
            chk({tag, " ram_addr"}, ram_addr, a);
            chk({tag, " ram_wdata"}, ram_wdata, d);
        end
        if (wr && io && lo == 3) chk({tag, " dsp_wdata"}, dsp_wdata, d);
        if (rd) chk({tag, " rdata"}, cpu_rdata, exp_read(a));
        @(posedge clk);
        model_step(a, d, rd, wr);
    endtask

    task automatic wr_(logic [15:0] a, logic [7:0] d, string tag); op(a, d, 0, 1, tag); endtask
    task automatic rd_(logic [15:0] a, string tag); op(a, 8'h00, 1, 0, tag); endtask
    task automatic idle(int n); for (int k = 0; k < n; k++) op(16'h0200, 8'h00, 0, 0, "R2 idle"); endtask

    initial begin
        #600000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        for (int i = 0; i < 256; i++) dsp_mem[i] = 8'(i ^ 8'h5C);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd_(16'h00F2, "R1 index");
        rd_(16'hFFC0, "R1 overlay");
        rd_(16'hFFFF, "R1 overlay");
        rd_(16'h00FD, "R1 cnt0");
        rd_(16'h00FF, "R1 cnt2");

        // R2 plain RAM
        wr_(16'h0040, 8'h5A, "R2");
        rd_(16'h0040, "R2");
        wr_(16'h0100, 8'h33, "R2");
        rd_(16'h0100, "R2");
        wr_(16'h00EF, 8'hC3, "R2");
        rd_(16'h00EF, "R2");

        // R3 overlay
        wr_(16'hFFC5, 8'h77, "R3 write under rom");
        rd_(16'hFFC5, "R3 rom byte");
        rd_(16'hFFE1, "R3 rom byte");
        wr_(16'hFFBF, 8'h11, "R3 below window");
        rd_(16'hFFBF, "R3 below window");
        wr_(16'h00F1, 8'h00, "R3 overlay off");
        rd_(16'hFFC5, "R3 ram visible");
        wr_(16'h00F1, 8'h80, "R3 overlay on");
        rd_(16'hFFC5, "R3 rom again");

        // R4 write-only / zero reads
        wr_(16'h00F0, 8'hFF, "R4 test reg");
        rd_(16'h00F0, "R4");
        rd_(16'h00F1, "R4");
        rd_(16'h00FB, "R4");

        // R5 DSP index / data
        wr_(16'h00F2, 8'h3C, "R5 index");
        rd_(16'h00F2, "R5 index");
        rd_(16'h00F3, "R5 data before");
        wr_(16'h00F3, 8'h99, "R5 data write");
        rd_(16'h00F3, "R5 data after");

        // R6 port bytes
        for (int i = 4; i <= 9; i++) wr_(16'h00F0 + 16'(i), 8'(8'h20 + i), "R6 write");
        for (int i = 4; i <= 9; i++) rd_(16'h00F0 + 16'(i), "R6 read");

        // R7 control clears
        wr_(16'h00F1, 8'h90, "R7 clear low");
        for (int i = 4; i <= 7; i++) rd_(16'h00F0 + 16'(i), "R7 after low");
        wr_(16'h00F1, 8'hA0, "R7 clear high");
        for (int i = 4; i <= 7; i++) rd_(16'h00F0 + 16'(i), "R7 after high");

        // R12 / R9 timer 2 with target 1
        wr_(16'h00FC, 8'h01, "R12 tgt2");
        wr_(16'h00F1, 8'h84, "R9 start t2");
        idle(100);
        rd_(16'h00FF, "R9 t2 count");
        rd_(16'h00FF, "R10 cleared");

        // R8 counter writes ignored
        idle(40);
        wr_(16'h00FF, 8'h0F, "R8 write ignored");
        rd_(16'h00FF, "R8 count intact");

        // R10 back-to-back reads overlapping wraps
        for (int k = 0; k < 70; k++) rd_(16'h00FF, "R10 read stream");
        // R10 wrap past 15
        idle(17 * 32 + 5);
        rd_(16'h00FF, "R10 wrap");

        // R9 timers 0 and 1, targets 2 and 3
        wr_(16'h00FA, 8'h02, "R12 tgt0");
        wr_(16'h00FB, 8'h03, "R12 tgt1");
        wr_(16'h00F1, 8'h87, "R9 start t0 t1");
        idle(1600);
        rd_(16'h00FD, "R9 t0 count");
        rd_(16'h00FE, "R9 t1 count");

        // R11 stop freezes, restart resets
        idle(600);
        wr_(16'h00F1, 8'h80, "R11 stop all");
        idle(900);
        rd_(16'h00FD, "R11 frozen t0");
        rd_(16'h00FE, "R11 frozen t1");
        wr_(16'h00F1, 8'h81, "R9 restart t0");
        idle(300);
        rd_(16'h00FD, "R9 restarted t0");

        // R9 target 0 means 256
        wr_(16'h00FC, 8'h00, "R12 tgt2 zero");
        wr_(16'h00F1, 8'h84, "R9 start t2");
        idle(256 * 32 - 10);
        rd_(16'h00FF, "R9 tgt0 before");
        idle(20);
        rd_(16'h00FF, "R9 tgt0 after");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule